// File: doc/BRIEF.md
# Serial ADC readout master

This block is the host-side controller that reads one conversion result from a three-wire serial converter. The wires are an active-low select, a serial clock and a data return line. An accepted start request pulls the select line low, which makes the converter begin a conversion and present its first bit at once. The block then generates a fixed number of serial-clock cycles by dividing the system clock. It captures one data bit per cycle, drops the four zero bits that open every frame, and presents the remaining bits as a parallel word together with a one-cycle valid strobe.

Two capture modes are supported. In falling-edge mode the serial clock rests high, and the bit present on the line is taken just before each falling edge. In rising-edge mode, meant for slow serial clocks, the clock rests low and each rising edge takes the bit launched on the falling edge before it. The result width is a parameter (8, 10 or 12 bits). A frame may be cut short with an abort input. After every frame the select line stays high for a programmable quiet time before another start is accepted.

Top module: `sadc_rd_master`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, cs_no is 1, sclk_o is 1, busy_o is 0, valid_o is 0, result_o is 0 and frame_err_o is 0.
- R2: A start_i sampled high in the idle state drives cs_no low in the next cycle. The frame then runs N = DATA_W+4 serial-clock cycles, and each clock phase lasts exactly DIV system cycles. valid_o goes high in the cycle that follows the clock edge 2*N*DIV cycles after the start edge.
- R3: With edge_mode_i = 0 (falling-edge capture), sclk_o rests at 1. The block captures sdata_i at each of the N falling edges, taking the bit present before that edge.
- R4: With edge_mode_i = 1 (rising-edge capture), sclk_o rests at 0. The block captures sdata_i at each of the N rising edges.
- R5: The last DATA_W captured bits, the first of them as the MSB, appear on result_o with a one-cycle valid_o pulse in the first cycle in which cs_no is high again. result_o and frame_err_o hold until the next valid_o.
- R6: frame_err_o is 1 together with valid_o if any of the first four captured bits was 1. Otherwise it is 0. The result is still presented.
- R7: abort_i sampled high while cs_no is low raises cs_no and returns sclk_o to its rest level in the next cycle. That frame never asserts valid_o and leaves result_o unchanged, and abort wins over completion on the same edge. abort_i has no effect while idle.
- R8: busy_o is high from the cycle after an accepted start until the quiet time ends. start_i is ignored while busy_o is high, including any change of edge_mode_i at that time.
- R9: With Q = quiet_cycles_i at frame end, busy_o stays high for Q+1 cycles counted from the valid_o cycle. If start_i is held high, cs_no stays high for exactly Q+2 cycles between frames.
- R10: cs_no never falls in the same cycle as an sclk_o edge, so the first bit of a frame is always set up before the first capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | request one conversion |
| abort_i | input | 1 | end the running frame without a result |
| edge_mode_i | input | 1 | 0: capture on falling edges, 1: capture on rising edges |
| quiet_cycles_i | input | QW | extra high time of the select line after a frame |
| sdata_i | input | 1 | serial data from the converter |
| cs_no | output | 1 | converter select, active low |
| sclk_o | output | 1 | serial clock |
| busy_o | output | 1 | frame or quiet time in progress |
| valid_o | output | 1 | one-cycle result strobe |
| result_o | output | DATA_W | conversion result |
| frame_err_o | output | 1 | a leading bit of the last frame was 1 |

## Verification
A bit counter that is off by one shows up within a single frame. The result comes out shifted by one position, and valid_o arrives one serial-clock period early or late against the 2*N*DIV count. A wrongly latched capture mode shows as the wrong sclk_o rest level when cs_no falls, and as bits taken on the launching edge, which corrupts the result of the first frame. A faulty quiet counter or busy condition changes the measured select-high gap or lets a second frame start. An abort that fails to clear the frame state shows as a stray valid_o within one frame time.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int unsigned LEAD_ZEROS = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACT   = 2'd1,
    ST_QUIET = 2'd2
  } sadc_state_e;

  function automatic int unsigned frame_len(input int unsigned width);
    return width + LEAD_ZEROS;
  endfunction
endpackage

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic idle_lvl_i,
  output logic sclk_o,
  output logic cap_o,
  output logic ret_o
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q;
  logic          phase_q;
  logic          sclk_q;
  logic          tick;

  assign tick   = run_i && (div_q == DW'(DIV - 1));
  assign cap_o  = tick && !phase_q;
  assign ret_o  = tick && phase_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      phase_q <= 1'b0;
      sclk_q  <= 1'b1;
    end else if (!run_i) begin
      div_q   <= '0;
      phase_q <= 1'b0;
      sclk_q  <= idle_lvl_i;
    end else if (tick) begin
      div_q   <= '0;
      phase_q <= ~phase_q;
      // phase 0 -> active level (capture edge), phase 1 -> back to rest
      sclk_q  <= phase_q ? idle_lvl_i : ~idle_lvl_i;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/sadc_frame_shift.sv
module sadc_frame_shift #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         cap_i,
  input  logic         bit_i,
  output logic [N-1:0] word_o,
  output logic         done_o
);
  localparam int unsigned CW = $clog2(N + 1);

  logic [N-1:0]  sh_q;
  logic [CW-1:0] cnt_q;

  assign word_o = sh_q;
  assign done_o = (cnt_q == CW'(N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (cap_i) begin
      sh_q  <= {sh_q[N-2:0], bit_i};
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sadc_quiet_tmr.sv
module sadc_quiet_tmr #(
  parameter int unsigned QW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [QW-1:0] lim_i,
  output logic          expired_o
);
  logic [QW-1:0] cnt_q;
  logic [QW-1:0] lim_q;

  assign expired_o = (cnt_q == lim_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      lim_q <= lim_i;
    end else if (!expired_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sadc_rd_master.sv
module sadc_rd_master
  import sadc_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DIV    = 2,
  parameter int unsigned QW     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              edge_mode_i,
  input  logic [QW-1:0]     quiet_cycles_i,
  input  logic              sdata_i,
  output logic              cs_no,
  output logic              sclk_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              frame_err_o
);
  localparam int unsigned N = frame_len(DATA_W);

  sadc_state_e       state_q;
  logic              mode_q;
  logic              cs_q;
  logic              valid_q;
  logic [DATA_W-1:0] result_q;
  logic              err_q;

  logic              run;
  logic              idle_lvl;
  logic              cap;
  logic              ret;
  logic              done;
  logic              frame_end;
  logic              quiet_load;
  logic              quiet_done;
  logic              start_ok;
  logic [N-1:0]      word;

  assign start_ok   = (state_q == ST_IDLE) && start_i;
  assign run        = (state_q == ST_ACT) && !abort_i;
  // rest level follows the live mode only while idle, then the latched one
  assign idle_lvl   = (state_q == ST_IDLE) ? ~edge_mode_i : ~mode_q;
  assign frame_end  = ret && done;
  assign quiet_load = (state_q == ST_ACT) && (abort_i || frame_end);

  sadc_sclk_gen #(.DIV(DIV)) u_sclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .idle_lvl_i (idle_lvl),
    .sclk_o     (sclk_o),
    .cap_o      (cap),
    .ret_o      (ret)
  );

  sadc_frame_shift #(.N(N)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_ok),
    .cap_i  (cap),
    .bit_i  (sdata_i),
    .word_o (word),
    .done_o (done)
  );

  sadc_quiet_tmr #(.QW(QW)) u_quiet (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (quiet_load),
    .lim_i     (quiet_cycles_i),
    .expired_o (quiet_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mode_q   <= 1'b0;
      cs_q     <= 1'b1;
      valid_q  <= 1'b0;
      result_q <= '0;
      err_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          mode_q <= edge_mode_i;
          if (start_i) begin
            cs_q    <= 1'b0;
            state_q <= ST_ACT;
          end
        end
        ST_ACT: begin
          if (abort_i) begin
            cs_q    <= 1'b1;
            state_q <= ST_QUIET;
          end else if (frame_end) begin
            cs_q     <= 1'b1;
            valid_q  <= 1'b1;
            result_q <= word[DATA_W-1:0];
            err_q    <= |word[N-1:DATA_W];
            state_q  <= ST_QUIET;
          end
        end
        ST_QUIET: begin
          if (quiet_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no       = cs_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign valid_o     = valid_q;
  assign result_o    = result_q;
  assign frame_err_o = err_q;
endmodule

// File: rtl/sadc_rd_master_chk.sv
module sadc_rd_master_chk #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DIV    = 2,
  parameter int unsigned QW     = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              abort_i,
  input logic              edge_mode_i,
  input logic [QW-1:0]     quiet_cycles_i,
  input logic              sdata_i,
  input logic              cs_no,
  input logic              sclk_o,
  input logic              busy_o,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              frame_err_o
);
  localparam int unsigned N  = DATA_W + 4;
  localparam int unsigned PW = $clog2(DIV + 2) + 1;
  localparam int unsigned TW = $clog2(2 * N + 1);

  logic          sclk_d;
  logic          cs_d;
  logic          ended_q;
  logic [PW-1:0] ph_q;
  logic [TW-1:0] tr_q;
  logic [2:0]    hi_q;
  logic          chg;

  assign chg = (sclk_o != sclk_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d  <= 1'b1;
      cs_d    <= 1'b1;
      ended_q <= 1'b0;
      ph_q    <= '0;
      tr_q    <= '0;
      hi_q    <= '0;
    end else begin
      sclk_d <= sclk_o;
      cs_d   <= cs_no;
      if (cs_no && !cs_d) ended_q <= 1'b1;
      if (chg) ph_q <= PW'(1);
      else if (ph_q != '1) ph_q <= ph_q + 1'b1;
      if (cs_no) tr_q <= '0;
      else if (chg) tr_q <= tr_q + 1'b1;
      if (!cs_no) hi_q <= '0;
      else if (hi_q != '1) hi_q <= hi_q + 1'b1;
    end
  end

  a_r5_valid_at_cs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (cs_no && !cs_d));

  a_r2_full_frame_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (tr_q == TW'(2 * N - 1) && chg));

  a_r2_phase_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg && !cs_no && !cs_d) |-> (ph_q >= PW'(DIV)));

  a_r8_busy_cover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o);

  a_r7_abort_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !cs_no) |=> (cs_no && !valid_o));

  a_r9_quiet_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_d && !cs_no && ended_q) |-> (hi_q >= 3'd2));

  a_r10_no_edge_at_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_d && !cs_no) |-> !chg);
endmodule

bind sadc_rd_master sadc_rd_master_chk #(
  .DATA_W (DATA_W),
  .DIV    (DIV),
  .QW     (QW)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .abort_i        (abort_i),
  .edge_mode_i    (edge_mode_i),
  .quiet_cycles_i (quiet_cycles_i),
  .sdata_i        (sdata_i),
  .cs_no          (cs_no),
  .sclk_o         (sclk_o),
  .busy_o         (busy_o),
  .valid_o        (valid_o),
  .result_o       (result_o),
  .frame_err_o    (frame_err_o)
);

// File: tb/sim_sadc_rd_master.sv
module sim_sadc_rd_master;
  localparam int DATA_W = 12;
  localparam int DIV    = 2;
  localparam int QW     = 4;
  localparam int N      = DATA_W + 4;
  localparam int FRAME  = 2 * N * DIV;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              abort = 1'b0;
  logic              edge_mode = 1'b0;
  logic [QW-1:0]     quiet = '0;
  logic              sdat = 1'b1;
  logic              cs_no, sclk, busy, valid, ferr;
  logic [DATA_W-1:0] result;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // converter model state
  logic [N-1:0] frame_word = '0;
  logic         cur_mode = 1'b0;
  int           bidx = 0;
  int           cap_cnt = 0;
  logic         prev_s = 1'b1;
  logic         prev_cs = 1'b1;

  always #10 clk = ~clk;

  sadc_rd_master #(.DATA_W(DATA_W), .DIV(DIV), .QW(QW)) u0 (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .start_i        (start),
    .abort_i        (abort),
    .edge_mode_i    (edge_mode),
    .quiet_cycles_i (quiet),
    .sdata_i        (sdat),
    .cs_no          (cs_no),
    .sclk_o         (sclk),
    .busy_o         (busy),
    .valid_o        (valid),
    .result_o       (result),
    .frame_err_o    (ferr)
  );

  // first bit on select fall, next bit after each falling sclk, line high after N
  always @(negedge clk) begin
    if (!cs_no && prev_cs) begin
      bidx    = 0;
      sdat    = frame_word[N-1];
      cap_cnt = 0;
    end else if (!cs_no) begin
      if (prev_s && !sclk) begin
        bidx = bidx + 1;
        sdat = (bidx < N) ? frame_word[N-1-bidx] : 1'b1;
      end
      if (sclk != prev_s && sclk == cur_mode) cap_cnt = cap_cnt + 1;
    end
    prev_s  = sclk;
    prev_cs = cs_no;
  end

  function automatic int exp_busy_len(input int q);
    return q + 1;
  endfunction

  function automatic logic exp_err(input logic [3:0] lead);
    return (lead != 4'd0);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_frame(input logic [DATA_W-1:0] val, input logic [3:0] lead,
                           input logic mode, input int q, input bit poke);
    int cnt;
    int bq;
    logic [DATA_W-1:0] r;
    wait_idle();
    frame_word = {lead, val};
    cur_mode   = mode;
    edge_mode  = mode;
    quiet      = QW'(q);
    @(negedge clk);
    chk(sclk == ~mode, mode ? "R4 rest level low" : "R3 rest level high", sclk, ~mode);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!cs_no && busy, "R2 select low, R8 busy", {cs_no, busy}, 2'b01);
    cnt = 1;
    while (!valid && cnt < 2 * FRAME + 8) begin
      if (poke && cnt == 7) begin start = 1'b1; edge_mode = ~mode; end
      if (poke && cnt == 8) start = 1'b0;
      @(negedge clk);
      cnt++;
    end
    chk(cnt == FRAME + 1, "R2 frame length", cnt, FRAME + 1);
    chk(cap_cnt == N, mode ? "R4 rising captures" : "R3 falling captures", cap_cnt, N);
    chk(result == val, mode ? "R4 result" : "R3 result", result, val);
    chk(ferr == exp_err(lead), "R6 frame error", ferr, exp_err(lead));
    chk(cs_no, "R5 valid with select high", cs_no, 1);
    r = result;
    start = poke;
    bq = 1;
    @(negedge clk);
    start = 1'b0;
    chk(!valid && result == r, "R5 single strobe, result held", {valid, result}, {1'b0, r});
    chk(cs_no, "R8 start ignored in quiet", cs_no, 1);
    while (busy && bq < 100) begin
      bq++;
      @(negedge clk);
    end
    chk(bq == exp_busy_len(q), "R9 busy through quiet", bq, exp_busy_len(q));
    edge_mode = mode;
  endtask

  task automatic abort_frame(input logic mode, input int k);
    int bad = 0;
    logic [DATA_W-1:0] r;
    wait_idle();
    r = result;
    frame_word = {4'd0, ~r};
    cur_mode   = mode;
    edge_mode  = mode;
    quiet      = QW'(2);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c < k; c++) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(cs_no && sclk == ~mode, "R7 abort releases select", {cs_no, sclk}, {1'b1, ~mode});
    for (int c = 0; c < FRAME + 20; c++) begin
      if (valid) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R7 no valid after abort", bad, 0);
    chk(result == r, "R7 result unchanged", result, r);
  endtask

  task automatic gap_test(input int q, input logic [DATA_W-1:0] val);
    int n = 0;
    int cnt = 0;
    wait_idle();
    frame_word = {4'd0, val};
    cur_mode   = 1'b1;
    edge_mode  = 1'b1;
    quiet      = QW'(q);
    @(negedge clk);
    start = 1'b1;
    while (!valid && cnt < 2 * FRAME + 8) begin @(negedge clk); cnt++; end
    while (cs_no && n < 100) begin n++; @(negedge clk); end
    start = 1'b0;
    chk(n == q + 2, "R9 select gap with start held", n, q + 2);
    cnt = 0;
    while (!valid && cnt < 2 * FRAME + 8) begin @(negedge clk); cnt++; end
    chk(valid && result == val, "R5 back-to-back result", result, val);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog R2 act=%0d exp=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7341);
    repeat (3) @(negedge clk);
    chk(cs_no && sclk && !busy && !valid && result == 0 && !ferr, "R1 reset state",
        {cs_no, sclk, busy, valid, ferr}, 5'b11000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_no && sclk && !busy && !valid, "R1 after release",
        {cs_no, sclk, busy, valid}, 4'b1100);

    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(cs_no && !busy, "R7 abort ignored when idle", {cs_no, busy}, 2'b10);

    run_frame(12'hFFF, 4'h0, 1'b0, 0, 1'b0);
    run_frame(12'hFFF, 4'h0, 1'b1, 1, 1'b0);
    run_frame(12'h000, 4'h0, 1'b0, 3, 1'b0);
    run_frame(12'h800, 4'h0, 1'b1, 2, 1'b0);
    run_frame(12'h001, 4'h0, 1'b0, 5, 1'b1);
    run_frame(12'hA5C, 4'h8, 1'b0, 1, 1'b0);
    run_frame(12'h3C6, 4'h1, 1'b1, 0, 1'b1);

    abort_frame(1'b0, 3);
    abort_frame(1'b1, FRAME);
    run_frame(12'h5A3, 4'h0, 1'b1, 2, 1'b0);

    gap_test(0, 12'h123);
    gap_test(5, 12'hE71);

    for (int i = 0; i < 24; i++) begin
      logic [DATA_W-1:0] v;
      logic [3:0] l;
      v = DATA_W'($urandom);
      l = ($urandom % 4 == 0) ? 4'($urandom) : 4'd0;
      run_frame(v, l, 1'($urandom), int'($urandom % 8), 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule